// File: doc/BRIEF.md
# Serial Byte-Memory Slave with Write Protection

This block is the slave side of an SPI (mode 0) link to a 512-byte memory held in an internal register array. The pins are sampled with the system clock. The block decodes a one-byte command and then takes a 9-bit start address: the top address bit sits inside the command byte and the other eight come in the next byte. After that it streams data bytes in or out, and the internal address advances after every byte.

Writes have no page limit. Each byte is committed as soon as its eighth bit arrives. Writes are gated in three ways: a write-enable latch, two block-protect bits in the status byte, and a write-protect pin that guards the status byte itself. A hold pin can freeze a transfer part way through. The transfer resumes where it stopped once hold is released.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, `so_en` is 0 and the status byte read by command 05h is 00h.
- R2: Command 06h sets the write-enable latch and command 04h clears it. The latch is visible as bit 1 of the status byte.
- R3: Commands 03h/0Bh (read) and 02h/0Ah (write) take address bit 8 from command bit 3. The next byte gives address bits 7..0.
- R4: During a read, each group of 8 SCK cycles after the address shifts out one byte, MSB first on SCK falling edges. The address advances by one per byte, and SI is ignored.
- R5: During a write with the latch set, every byte after the address is stored at its 8th rising SCK edge, with no limit on the count. With the latch clear, nothing is stored.
- R6: The address counter wraps from 1FFh to 000h for both reads and writes.
- R7: The CS_n rising edge that ends a write command or a status-write command clears the write-enable latch.
- R8: The block-protect bits (status bits 3:2) select the protected range: 00 none, 01 180h–1FFh, 10 100h–1FFh, 11 all. A byte aimed at a protected address is dropped, and the address still advances.
- R9: Command 01h writes status bits 3:2 from data bits 3:2. This happens only when the latch is set and WP_n is high; otherwise the status byte is unchanged.
- R10: HOLD_n low taken while SCK is low freezes the transfer, and SCK edges have no effect. `so_en` is 0 during hold. HOLD_n high taken while SCK is low resumes the transfer.
- R11: `so_en` is 0 while CS_n is high.
- R12: Any other command byte is ignored until CS_n rises. Later bytes in the same selection have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data into the slave |
| wp_n | input | 1 | Status-byte write protect, active low |
| hold_n | input | 1 | Transfer pause, active low |
| so | output | 1 | Serial data out of the slave |
| so_en | output | 1 | Output enable for `so` (stands for the high-impedance control) |

## Verification
A table of single-byte write/read pairs covers addresses with bit 8 both clear and set, and both ends of each half of the array. This separates a correct A8 decode from a dropped or misplaced bit. Multi-byte bursts that cross 1FFh show the wrap and the per-byte increment, and dummy SI bytes during reads show that SI is ignored. Protection runs write across the edge of a protected range, so a dropped byte is told apart from a stalled address. Status writes are tried with the latch clear, with WP_n low, and with both conditions met. A hold inserted mid-byte, with SCK toggling and SI changing, must leave the stored byte intact.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam int unsigned MEM_AW    = 9;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned MEM_DEPTH = 1 << MEM_AW;
  localparam int unsigned BIT_CW    = $clog2(BYTE_W);
  localparam int unsigned HI_BIT    = 3;

  localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WRDI = 8'h04;
  localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WRSR = 8'h01;
  localparam logic [BYTE_W-1:0] OP_READ = 8'h03;
  localparam logic [BYTE_W-1:0] OP_WRIT = 8'h02;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_RD, ST_WR, ST_RDSR, ST_WRSR, ST_IGN
  } xfer_state_t;

  function automatic logic in_protected(input logic [1:0] bp,
                                        input logic [MEM_AW-1:0] a);
    case (bp)
      2'b00:   in_protected = 1'b0;
      2'b01:   in_protected = (a[MEM_AW-1:MEM_AW-2] == 2'b11);
      2'b10:   in_protected = a[MEM_AW-1];
      default: in_protected = 1'b1;
    endcase
  endfunction

  function automatic logic [MEM_AW-1:0] next_addr(input logic [MEM_AW-1:0] a);
    next_addr = a + 1'b1;
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic [1:0] bp,
                                                    input logic wel);
    status_byte = {4'b0000, bp, wel, 1'b0};
  endfunction

  function automatic logic [BYTE_W-1:0] strip_hi(input logic [BYTE_W-1:0] c);
    strip_hi = c & ~(BYTE_W'(1) << HI_BIT);
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] pins_raw,   // {cs_n, hold_n, wp_n, sck, si}
  output logic       cs_hi,
  output logic       cs_rise,
  output logic       sck_rise,
  output logic       sck_fall,
  output logic       si_s,
  output logic       wp_s,
  output logic       hold_q
);
  localparam logic [4:0] IDLE_PINS = 5'b11100;

  logic [4:0] stg [STAGES];
  logic [4:0] prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stg[0] <= IDLE_PINS;
    else        stg[0] <= pins_raw;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stg[g] <= IDLE_PINS;
      else        stg[g] <= stg[g-1];
  end

  wire [4:0] now = stg[STAGES-1];
  wire hold_fell = prev[3] & ~now[3];
  wire hold_rose = ~prev[3] & now[3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev   <= IDLE_PINS;
      hold_q <= 1'b0;
    end else begin
      prev <= now;
      if (hold_fell && !now[1])      hold_q <= 1'b1;
      else if (hold_rose && !now[1]) hold_q <= 1'b0;
    end

  assign cs_hi    = now[4];
  assign cs_rise  = now[4] & ~prev[4];
  assign sck_rise = now[1] & ~prev[1] & ~hold_q;
  assign sck_fall = ~now[1] & prev[1] & ~hold_q;
  assign si_s     = now[0];
  assign wp_s     = now[2];
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array
  import spi_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MEM_AW-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] cells [MEM_DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < MEM_DEPTH; i++) cells[i] <= '0;
    end else if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/spi_mem_core.sv
module spi_mem_core
  import spi_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              si_s,
  input  logic              wp_s,
  input  logic              hold_q,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [MEM_AW-1:0] rd_addr,
  output logic [MEM_AW-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_en,
  output logic              so_bit
);
  xfer_state_t       st;
  logic [BIT_CW-1:0] bitcnt;
  logic [BYTE_W-1:0] sh, osr;
  logic [MEM_AW-1:0] addr;
  logic              a8, rd_mode, wel, clr_pend;
  logic [1:0]        bp;

  wire [BYTE_W-1:0] nb        = {sh[BYTE_W-2:0], si_s};
  wire              byte_done = sck_rise && (bitcnt == BIT_CW'(BYTE_W-1));
  wire              wren_hit  = byte_done && (st == ST_CMD) && (nb == OP_WREN);
  wire              addr_step = byte_done && (st == ST_RD || st == ST_WR);
  wire              bp_we     = byte_done && (st == ST_WRSR) && wel && wp_s;

  assign wr_en   = byte_done && (st == ST_WR) && wel && !in_protected(bp, addr);
  assign wr_addr = addr;
  assign wr_data = nb;
  assign rd_addr = (st == ST_ADDR) ? {a8, nb} : next_addr(addr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_CMD; bitcnt <= '0; sh <= '0; osr <= '0; addr <= '0;
      a8 <= 1'b0; rd_mode <= 1'b0; wel <= 1'b0; clr_pend <= 1'b0;
      bp <= 2'b00; so_bit <= 1'b0;
    end else begin
      if (cs_rise) begin
        clr_pend <= 1'b0;
        if (clr_pend) wel <= 1'b0;
      end
      if (cs_hi) begin
        st     <= ST_CMD;
        bitcnt <= '0;
      end else if (sck_rise) begin
        sh     <= nb;
        bitcnt <= bitcnt + 1'b1;
        if (byte_done) begin
          unique case (st)
            ST_CMD: begin
              if (nb == OP_WREN) begin
                wel <= 1'b1; st <= ST_IGN;
              end else if (nb == OP_WRDI) begin
                wel <= 1'b0; st <= ST_IGN;
              end else if (nb == OP_RDSR) begin
                osr <= status_byte(bp, wel); st <= ST_RDSR;
              end else if (nb == OP_WRSR) begin
                clr_pend <= 1'b1; st <= ST_WRSR;
              end else if (strip_hi(nb) == OP_READ) begin
                a8 <= nb[HI_BIT]; rd_mode <= 1'b1; st <= ST_ADDR;
              end else if (strip_hi(nb) == OP_WRIT) begin
                a8 <= nb[HI_BIT]; rd_mode <= 1'b0; clr_pend <= 1'b1; st <= ST_ADDR;
              end else begin
                st <= ST_IGN;
              end
            end
            ST_ADDR: begin
              addr <= {a8, nb};
              if (rd_mode) begin osr <= rd_data; st <= ST_RD; end
              else         st <= ST_WR;
            end
            ST_RD: begin
              addr <= next_addr(addr);
              osr  <= rd_data;
            end
            ST_WR:   addr <= next_addr(addr);
            ST_RDSR: osr  <= status_byte(bp, wel);
            ST_WRSR: begin
              if (bp_we) bp <= nb[3:2];
              st <= ST_IGN;
            end
            default: ;
          endcase
        end
      end
      if (sck_fall && !cs_hi) begin
        so_bit <= osr[BYTE_W-1];
        osr    <= {osr[BYTE_W-2:0], 1'b0};
      end
    end

  // R6: the counter rolls over from the top address to zero
  a_r6_addr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_step && addr == MEM_AW'(MEM_DEPTH-1)) |=> (addr == '0));

  // R7: ending a write or status-write selection drops the latch
  a_r7_wel_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && clr_pend) |=> !wel);

  // R2: the latch only rises after a write-enable command byte
  a_r2_wel_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(wren_hit));

  // R9: block-protect bits move only on an accepted status write
  a_r9_bp_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !bp_we |=> $stable(bp));

  // R10: nothing advances while the transfer is held
  a_r10_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !cs_hi) |=> ($stable(bitcnt) && $stable(addr) && $stable(osr)));
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  input  logic hold_n,
  output logic so,
  output logic so_en
);
  logic cs_hi, cs_rise, sck_rise, sck_fall, si_s, wp_s, hold_q;
  logic wr_en, so_bit;
  logic [MEM_AW-1:0] rd_addr, wr_addr;
  logic [BYTE_W-1:0] rd_data, wr_data;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .pins_raw({cs_n, hold_n, wp_n, sck, si}),
    .cs_hi(cs_hi), .cs_rise(cs_rise), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .si_s(si_s), .wp_s(wp_s), .hold_q(hold_q)
  );

  spi_mem_core core_i (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s), .wp_s(wp_s),
    .hold_q(hold_q), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en), .so_bit(so_bit)
  );

  spi_mem_array mem_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign so    = so_bit;
  assign so_en = ~cs_hi & ~hold_q;

  // R11: output stays disabled in any cycle after CS_n has been seen high
  a_r11_so_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_hi) && cs_hi |-> !so_en);
endmodule

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb_top;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1, hold_n = 1'b1;
  logic so, so_en;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  spi_mem_slave dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .si(si), .wp_n(wp_n), .hold_n(hold_n), .so(so), .so_en(so_en));

  // {addr[8:0], data[7:0]}
  localparam logic [16:0] VEC [6] = '{
    {9'h000, 8'h3C}, {9'h0FF, 8'hA5}, {9'h100, 8'h5A},
    {9'h17F, 8'hC6}, {9'h1A5, 8'h81}, {9'h1FF, 8'hE7}
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic r);
    si = b; wait_n(H); r = so; sck = 1'b1; wait_n(H); sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
  endtask

  task automatic sel();   cs_n = 1'b0; wait_n(H);   endtask
  task automatic desel(); wait_n(H); cs_n = 1'b1; wait_n(2*H); endtask

  task automatic op1(input logic [7:0] c);
    logic [7:0] d;
    sel(); spi_byte(c, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel(); spi_byte(8'h05, d); spi_byte(8'h00, s); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    sel(); spi_byte(8'h01, d); spi_byte(v, d); desel();
  endtask

  task automatic wr_start(input logic [8:0] a);
    logic [7:0] d;
    sel(); spi_byte(8'h02 | {4'b0, a[8], 3'b0}, d); spi_byte(a[7:0], d);
  endtask

  task automatic rd_start(input logic [8:0] a);
    logic [7:0] d;
    sel(); spi_byte(8'h03 | {4'b0, a[8], 3'b0}, d); spi_byte(a[7:0], d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] s, d, r;
    logic       b;
    wait_n(5); rst_n = 1'b1; wait_n(5);

    // R1 / R11: reset state
    check("R1 so_en", {7'b0, so_en}, 8'h00);
    rdsr(s); check("R1 status", s, 8'h00);
    check("R11 so_en after deselect", {7'b0, so_en}, 8'h00);

    // R2: latch set and clear
    op1(8'h06); rdsr(s); check("R2 wren", s, 8'h02);
    op1(8'h04); rdsr(s); check("R2 wrdi", s, 8'h00);

    // R3 / R5: vector table, single byte write then read
    foreach (VEC[k]) begin
      op1(8'h06);
      wr_start(VEC[k][16:8]); spi_byte(VEC[k][7:0], d); desel();
      rd_start(VEC[k][16:8]); spi_byte(8'h00, r); desel();
      check("R3 R5 table", r, VEC[k][7:0]);
    end

    // R5: write without latch is not stored
    wr_start(9'h010); spi_byte(8'h55, d); desel();
    rd_start(9'h010); spi_byte(8'h00, r); desel();
    check("R5 no latch", r, 8'h00);

    // R6 / R4 / R7: burst across the top, dummy SI during read
    op1(8'h06);
    wr_start(9'h1FE);
    spi_byte(8'h12, d); spi_byte(8'h34, d); spi_byte(8'h56, d); spi_byte(8'h78, d);
    desel();
    rdsr(s); check("R7 latch cleared after write", s, 8'h00);
    rd_start(9'h1FE);
    spi_byte(8'hFF, r); check("R4 burst 1FE", r, 8'h12);
    spi_byte(8'hA5, r); check("R6 burst 1FF", r, 8'h34);
    spi_byte(8'h02, r); check("R6 wrap 000", r, 8'h56);
    spi_byte(8'h06, r); check("R4 burst 001", r, 8'h78);
    desel();

    // R9 / R8: protect upper quarter
    op1(8'h06); wrsr(8'h04); rdsr(s); check("R9 wrsr bp01", s, 8'h04);
    op1(8'h06);
    wr_start(9'h17F); spi_byte(8'h11, d); spi_byte(8'h22, d); desel();
    rd_start(9'h17F); spi_byte(8'h00, r); check("R8 bp01 open", r, 8'h11);
    spi_byte(8'h00, r); check("R8 bp01 protected", r, 8'h00); desel();

    // R8: protect upper half, increment continues past dropped byte
    op1(8'h06); wrsr(8'h08);
    op1(8'h06);
    wr_start(9'h1FF); spi_byte(8'h77, d); spi_byte(8'h88, d); desel();
    rd_start(9'h1FF); spi_byte(8'h00, r); check("R8 bp10 dropped", r, 8'h34);
    spi_byte(8'h00, r); check("R8 address advanced", r, 8'h88); desel();

    // R9: status write guards
    wrsr(8'h0C); rdsr(s); check("R9 no latch", s, 8'h08);
    wp_n = 1'b0;
    op1(8'h06); wrsr(8'h0C); rdsr(s); check("R9 wp low", s, 8'h08);
    wp_n = 1'b1;
    op1(8'h06); wrsr(8'h00); rdsr(s); check("R9 accepted", s, 8'h00);

    // R12: unknown command swallows later bytes
    op1(8'h06);
    sel(); spi_byte(8'h5A, d); spi_byte(8'h02, d); spi_byte(8'h00, d);
    spi_byte(8'h99, d); desel();
    rd_start(9'h000); spi_byte(8'h00, r); desel();
    check("R12 memory untouched", r, 8'h88);
    rdsr(s); check("R12 latch untouched", s, 8'h02);

    // R10: hold in the middle of a data byte
    wr_start(9'h050);
    for (int i = 7; i >= 4; i--) spi_bit(d_bit(8'hC3, i), b);
    wait_n(H); hold_n = 1'b0; wait_n(H);
    check("R10 so_en in hold", {7'b0, so_en}, 8'h00);
    for (int j = 0; j < 3; j++) begin
      si = j[0]; sck = 1'b1; wait_n(H); sck = 1'b0; wait_n(H);
    end
    hold_n = 1'b1; wait_n(H);
    for (int i = 3; i >= 0; i--) spi_bit(d_bit(8'hC3, i), b);
    desel();
    rd_start(9'h050); spi_byte(8'h00, r); desel();
    check("R10 byte after hold", r, 8'hC3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic d_bit(input logic [7:0] v, input int i);
    d_bit = v[i];
  endfunction
endmodule